// File: doc/BRIEF.md
# Pipelined Floating-Point Adder-Subtractor

This block adds or subtracts two numbers held in a compact floating-point form. Each number has a sign bit, an unsigned exponent field and a fractional magnitude mantissa. Work is spread over four registered stages:

- exponent comparison by subtraction;
- right-shift alignment of the operand with the smaller exponent;
- signed-magnitude add or subtract of the mantissas;
- normalization with exponent correction.

A new operation may enter on every clock, and each result leaves exactly four clocks after its operands entered.

The last stage sorts every result into one of four named normalization cases. The cases are chosen combinationally per result; there is no sequencing between them.

- NORM_ZERO: the mantissa sum is zero.
- NORM_CARRY: the sum carried out of the mantissa width.
- NORM_LEFT: leading zeros must be removed.
- NORM_KEEP: the sum is already normalized.

Every result passes through exactly one of these cases on its way to the output register. The stage-1 exponent difference is carried forward and drives the stage-2 shift directly. Rounding, denormals, special values and exceptions are not handled. Bits shifted out during alignment are discarded.

Top module: `fpa_pipe`

## Requirements
- R1: A word is {sign (top bit), exponent (EXP_W bits), mantissa (MAN_W low bits)}. Its value is (-1)^sign * (mantissa / 2^MAN_W) * 2^exponent. Operands are either normalized (mantissa MSB = 1) or all-zero.
- R2: out_valid equals in_valid from exactly four clocks earlier, and back-to-back operations are all accepted.
- R3: in_sub = 0 computes opa + opb; in_sub = 1 computes opa - opb.
- R4: The larger exponent becomes the provisional result exponent. The other mantissa is shifted right by the exponent difference, and bits shifted out are dropped.
- R5: An exponent difference of MAN_W or more aligns the smaller operand to zero, so the result equals the larger-exponent operand (with its sign negated when it is the subtracted opb).
- R6: A carry out of the mantissa add shifts the mantissa right by one (dropping its LSB) and increments the exponent (NORM_CARRY).
- R7: Leading zeros in the sum are removed by a left shift, and the exponent is decremented by the shift count (NORM_LEFT).
- R8: A zero mantissa sum yields an all-zero output word, sign included (NORM_ZERO).
- R9: For operands of unlike effective sign, the result sign is that of the operand with the larger aligned mantissa.
- R10: While reset is held, out_valid is 0 and out_res is all-zero.
- R11: Every valid result has a zero mantissa or a mantissa whose MSB is 1.
- R12: Adding or subtracting an all-zero opb returns opa unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands present this clock |
| in_sub | input | 1 | 1 = subtract opb from opa, 0 = add |
| opa | input | 1+EXP_W+MAN_W | First operand |
| opb | input | 1+EXP_W+MAN_W | Second operand |
| out_valid | output | 1 | Result present |
| out_res | output | 1+EXP_W+MAN_W | Result word |

## Verification
The assertions watch four behaviours on every cycle:

- the four-clock valid latency;
- the normalized form of each valid result;
- the all-zero encoding of a zero result;
- the identity behaviour when opb is zero.

The exact mantissa and exponent produced by alignment truncation, carry handling, multi-bit left normalization and sign selection can only be shown by the bench's directed scenarios. The same holds for the very-large exponent gap and for a random back-to-back stream compared against a reference model.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
    typedef enum logic [1:0] {
        NORM_ZERO,
        NORM_CARRY,
        NORM_LEFT,
        NORM_KEEP
    } fpa_norm_e;
endpackage

// File: rtl/fpa_compare.sv
module fpa_compare #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16,
    localparam int WORD_W = 1 + EXP_W + MAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sub,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic              s1_valid,
    output logic              s1_sign_x,
    output logic              s1_sign_y,
    output logic [MAN_W-1:0]  s1_man_x,
    output logic [MAN_W-1:0]  s1_man_y,
    output logic [EXP_W-1:0]  s1_exp,
    output logic [EXP_W-1:0]  s1_diff
);
    logic [EXP_W-1:0] exp_a, exp_b;
    logic [EXP_W:0]   diff_raw;
    logic             a_wins;
    logic             sign_b_eff;

    always_comb begin
        exp_a      = opa[MAN_W +: EXP_W];
        exp_b      = opb[MAN_W +: EXP_W];
        diff_raw   = {1'b0, exp_a} - {1'b0, exp_b};
        a_wins     = ~diff_raw[EXP_W];
        sign_b_eff = opb[WORD_W-1] ^ in_sub;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_sign_x <= 1'b0;
            s1_sign_y <= 1'b0;
            s1_man_x  <= '0;
            s1_man_y  <= '0;
            s1_exp    <= '0;
            s1_diff   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (a_wins) begin
                s1_sign_x <= opa[WORD_W-1];
                s1_man_x  <= opa[MAN_W-1:0];
                s1_sign_y <= sign_b_eff;
                s1_man_y  <= opb[MAN_W-1:0];
                s1_exp    <= exp_a;
                s1_diff   <= diff_raw[EXP_W-1:0];
            end else begin
                s1_sign_x <= sign_b_eff;
                s1_man_x  <= opb[MAN_W-1:0];
                s1_sign_y <= opa[WORD_W-1];
                s1_man_y  <= opa[MAN_W-1:0];
                s1_exp    <= exp_b;
                s1_diff   <= exp_b - exp_a;
            end
        end
    end
endmodule

// File: rtl/fpa_align.sv
module fpa_align #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s1_valid,
    input  logic              s1_sign_x,
    input  logic              s1_sign_y,
    input  logic [MAN_W-1:0]  s1_man_x,
    input  logic [MAN_W-1:0]  s1_man_y,
    input  logic [EXP_W-1:0]  s1_exp,
    input  logic [EXP_W-1:0]  s1_diff,
    output logic              s2_valid,
    output logic              s2_sign_x,
    output logic              s2_sign_y,
    output logic [MAN_W-1:0]  s2_man_x,
    output logic [MAN_W-1:0]  s2_man_y,
    output logic [EXP_W-1:0]  s2_exp
);
    localparam int CMP_W = (EXP_W > 31) ? EXP_W + 1 : 32;

    logic [MAN_W-1:0] man_y_aligned;
    logic             flush_y;

    always_comb begin
        flush_y = CMP_W'(s1_diff) >= CMP_W'(MAN_W);
        if (flush_y) man_y_aligned = '0;
        else         man_y_aligned = s1_man_y >> s1_diff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid  <= 1'b0;
            s2_sign_x <= 1'b0;
            s2_sign_y <= 1'b0;
            s2_man_x  <= '0;
            s2_man_y  <= '0;
            s2_exp    <= '0;
        end else begin
            s2_valid  <= s1_valid;
            s2_sign_x <= s1_sign_x;
            s2_sign_y <= s1_sign_y;
            s2_man_x  <= s1_man_x;
            s2_man_y  <= man_y_aligned;
            s2_exp    <= s1_exp;
        end
    end
endmodule

// File: rtl/fpa_addsub.sv
module fpa_addsub #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s2_valid,
    input  logic              s2_sign_x,
    input  logic              s2_sign_y,
    input  logic [MAN_W-1:0]  s2_man_x,
    input  logic [MAN_W-1:0]  s2_man_y,
    input  logic [EXP_W-1:0]  s2_exp,
    output logic              s3_valid,
    output logic              s3_sign,
    output logic [MAN_W:0]    s3_sum,
    output logic [EXP_W-1:0]  s3_exp
);
    logic [MAN_W:0] ext_x, ext_y, sum_next;
    logic           sign_next;

    always_comb begin
        ext_x = {1'b0, s2_man_x};
        ext_y = {1'b0, s2_man_y};
        if (s2_sign_x == s2_sign_y) begin
            sum_next  = ext_x + ext_y;
            sign_next = s2_sign_x;
        end else if (ext_x >= ext_y) begin
            sum_next  = ext_x - ext_y;
            sign_next = s2_sign_x;
        end else begin
            sum_next  = ext_y - ext_x;
            sign_next = s2_sign_y;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s3_valid <= 1'b0;
            s3_sign  <= 1'b0;
            s3_sum   <= '0;
            s3_exp   <= '0;
        end else begin
            s3_valid <= s2_valid;
            s3_sign  <= sign_next;
            s3_sum   <= sum_next;
            s3_exp   <= s2_exp;
        end
    end
endmodule

// File: rtl/fpa_normalize.sv
module fpa_normalize
    import fpa_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16,
    localparam int WORD_W = 1 + EXP_W + MAN_W,
    localparam int LZ_W   = $clog2(MAN_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s3_valid,
    input  logic              s3_sign,
    input  logic [MAN_W:0]    s3_sum,
    input  logic [EXP_W-1:0]  s3_exp,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_res
);
    fpa_norm_e        kind;
    logic [LZ_W-1:0]  lead_zeros;
    logic             seen_one;
    logic [MAN_W-1:0] man_next;
    logic [EXP_W-1:0] exp_next;
    logic             sign_next;

    always_comb begin
        lead_zeros = '0;
        seen_one   = 1'b0;
        for (int i = MAN_W - 1; i >= 0; i--) begin
            if (!seen_one && s3_sum[i]) begin
                lead_zeros = LZ_W'(MAN_W - 1 - i);
                seen_one   = 1'b1;
            end
        end
    end

    always_comb begin
        if (s3_sum[MAN_W])        kind = NORM_CARRY;
        else if (!seen_one)       kind = NORM_ZERO;
        else if (lead_zeros != 0) kind = NORM_LEFT;
        else                      kind = NORM_KEEP;
    end

    always_comb begin
        man_next  = s3_sum[MAN_W-1:0];
        exp_next  = s3_exp;
        sign_next = s3_sign;
        unique case (kind)
            NORM_ZERO: begin
                man_next  = '0;
                exp_next  = '0;
                sign_next = 1'b0;
            end
            NORM_CARRY: begin
                man_next = s3_sum[MAN_W:1];
                exp_next = s3_exp + 1'b1;
            end
            NORM_LEFT: begin
                man_next = s3_sum[MAN_W-1:0] << lead_zeros;
                exp_next = s3_exp - EXP_W'(lead_zeros);
            end
            NORM_KEEP: begin
                man_next = s3_sum[MAN_W-1:0];
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else begin
            out_valid <= s3_valid;
            out_res   <= {sign_next, exp_next, man_next};
        end
    end
endmodule

// File: rtl/fpa_pipe.sv
module fpa_pipe #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16,
    localparam int WORD_W = 1 + EXP_W + MAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sub,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_res
);
    logic             s1_valid, s1_sign_x, s1_sign_y;
    logic [MAN_W-1:0] s1_man_x, s1_man_y;
    logic [EXP_W-1:0] s1_exp, s1_diff;
    logic             s2_valid, s2_sign_x, s2_sign_y;
    logic [MAN_W-1:0] s2_man_x, s2_man_y;
    logic [EXP_W-1:0] s2_exp;
    logic             s3_valid, s3_sign;
    logic [MAN_W:0]   s3_sum;
    logic [EXP_W-1:0] s3_exp;

    fpa_compare #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
        .opa(opa), .opb(opb),
        .s1_valid(s1_valid), .s1_sign_x(s1_sign_x), .s1_sign_y(s1_sign_y),
        .s1_man_x(s1_man_x), .s1_man_y(s1_man_y),
        .s1_exp(s1_exp), .s1_diff(s1_diff)
    );

    fpa_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_aln (
        .clk(clk), .rst_n(rst_n),
        .s1_valid(s1_valid), .s1_sign_x(s1_sign_x), .s1_sign_y(s1_sign_y),
        .s1_man_x(s1_man_x), .s1_man_y(s1_man_y),
        .s1_exp(s1_exp), .s1_diff(s1_diff),
        .s2_valid(s2_valid), .s2_sign_x(s2_sign_x), .s2_sign_y(s2_sign_y),
        .s2_man_x(s2_man_x), .s2_man_y(s2_man_y), .s2_exp(s2_exp)
    );

    fpa_addsub #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_add (
        .clk(clk), .rst_n(rst_n),
        .s2_valid(s2_valid), .s2_sign_x(s2_sign_x), .s2_sign_y(s2_sign_y),
        .s2_man_x(s2_man_x), .s2_man_y(s2_man_y), .s2_exp(s2_exp),
        .s3_valid(s3_valid), .s3_sign(s3_sign), .s3_sum(s3_sum), .s3_exp(s3_exp)
    );

    fpa_normalize #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_nrm (
        .clk(clk), .rst_n(rst_n),
        .s3_valid(s3_valid), .s3_sign(s3_sign), .s3_sum(s3_sum), .s3_exp(s3_exp),
        .out_valid(out_valid), .out_res(out_res)
    );
endmodule

// File: rtl/fpa_pipe_chk.sv
module fpa_pipe_chk #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 16,
    localparam int WORD_W = 1 + EXP_W + MAN_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] opa,
    input logic [WORD_W-1:0] opb,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_res
);
    logic [3:0] since_rst;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 4'd8) since_rst <= since_rst + 4'd1;
    end

    assign warm = since_rst >= 4'd5;

    // R2
    latency_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 4)));

    // R11
    result_normalized_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_res[MAN_W-1:0] != '0) |-> out_res[MAN_W-1]);

    // R8
    zero_encoding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_res[MAN_W-1:0] == '0) |-> (out_res == '0));

    // R12
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_valid, 4) && $past(opb, 4) == '0 && $past(opa[MAN_W-1], 4))
        |-> (out_res == $past(opa, 4)));
endmodule

bind fpa_pipe fpa_pipe_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
    .out_valid(out_valid), .out_res(out_res)
);

// File: tb/tb_fpa_pipe.sv
module tb_fpa_pipe;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 16;
    localparam int WORD_W = 1 + EXP_W + MAN_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_sub = 1'b0;
    logic [WORD_W-1:0] opa = '0;
    logic [WORD_W-1:0] opb = '0;
    logic              out_valid;
    logic [WORD_W-1:0] out_res;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    fpa_pipe #(.EXP_W(EXP_W), .MAN_W(MAN_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
        .opa(opa), .opb(opb), .out_valid(out_valid), .out_res(out_res)
    );

    function automatic logic [WORD_W-1:0] mk(bit s, int e, int m);
        return {s, EXP_W'(e), MAN_W'(m)};
    endfunction

    function automatic logic [WORD_W-1:0] ref_add(logic [WORD_W-1:0] a, logic [WORD_W-1:0] b, bit sub);
        int ea, eb, ex, d, mx, my, s;
        bit sx, sy, sr, sb;
        ea = int'(a[MAN_W +: EXP_W]);
        eb = int'(b[MAN_W +: EXP_W]);
        sb = b[WORD_W-1] ^ sub;
        if (ea >= eb) begin
            ex = ea; d = ea - eb; sx = a[WORD_W-1]; sy = sb;
            mx = int'(a[MAN_W-1:0]); my = int'(b[MAN_W-1:0]);
        end else begin
            ex = eb; d = eb - ea; sx = sb; sy = a[WORD_W-1];
            mx = int'(b[MAN_W-1:0]); my = int'(a[MAN_W-1:0]);
        end
        my = (d >= MAN_W) ? 0 : (my >> d);
        if (sx == sy)     begin s = mx + my; sr = sx; end
        else if (mx >= my) begin s = mx - my; sr = sx; end
        else              begin s = my - mx; sr = sy; end
        if (s == 0) return '0;
        if (s >= (1 << MAN_W)) begin s = s >> 1; ex++; end
        else while (s < (1 << (MAN_W - 1))) begin s = s << 1; ex--; end
        return mk(sr, ex, s);
    endfunction

    task automatic check(string req, logic [WORD_W-1:0] got, logic [WORD_W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // single operation, result sampled four negedges after it is driven
    task automatic run_one(string req, logic [WORD_W-1:0] a, logic [WORD_W-1:0] b,
                           bit sub, logic [WORD_W-1:0] exp);
        @(negedge clk);
        in_valid = 1'b1; in_sub = sub; opa = a; opb = b;
        @(negedge clk);
        in_valid = 1'b0; opa = '0; opb = '0; in_sub = 1'b0;
        repeat (3) @(negedge clk);
        check({req, " valid"}, WORD_W'(out_valid), WORD_W'(1));
        check(req, out_res, exp);
    endtask

    task automatic t_reset();
        // R10
        check("R10 valid", WORD_W'(out_valid), WORD_W'(0));
        check("R10 result", out_res, '0);
    endtask

    task automatic t_latency();
        // R2: valid appears on the fourth clock, not before
        @(negedge clk);
        in_valid = 1'b1; opa = mk(0, 30, 'h8000); opb = mk(0, 30, 'h8000);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 early", WORD_W'(out_valid), WORD_W'(0));
        @(negedge clk);
        check("R2 on time", WORD_W'(out_valid), WORD_W'(1));
        @(negedge clk);
        check("R2 single", WORD_W'(out_valid), WORD_W'(0));
    endtask

    task automatic t_arith();
        run_one("R6 carry",        mk(0, 3, 'h8000), mk(0, 3, 'h8000), 0, mk(0, 4, 'h8000));
        run_one("R3 R7 sub",       mk(0, 5, 'hC000), mk(0, 5, 'h8000), 1, mk(0, 4, 'h8000));
        run_one("R4 align",        mk(0, 4, 'h8000), mk(0, 2, 'h8000), 0, mk(0, 4, 'hA000));
        run_one("R4 truncate",     mk(0, 4, 'h8000), mk(0, 0, 'hFFFF), 0, mk(0, 4, 'h8FFF));
        run_one("R5 far add",      mk(0, 40, 'h8000), mk(0, 10, 'hFFFF), 0, mk(0, 40, 'h8000));
        run_one("R5 far sub",      mk(0, 10, 'hFFFF), mk(0, 40, 'h8000), 1, mk(1, 40, 'h8000));
        run_one("R5 edge gap",     mk(0, 36, 'h8000), mk(0, 20, 'hFFFF), 0, mk(0, 36, 'h8000));
        run_one("R7 deep",         mk(0, 20, 'h8001), mk(0, 20, 'h8000), 1, mk(0, 5, 'h8000));
        run_one("R9 sign",         mk(0, 3, 'h8000), mk(0, 3, 'hC000), 1, mk(1, 2, 'h8000));
        run_one("R9 neg add",      mk(1, 6, 'hF000), mk(0, 6, 'h8000), 0, mk(1, 5, 'hE000));
        run_one("R8 cancel",       mk(0, 7, 'h9000), mk(0, 7, 'h9000), 1, '0);
        run_one("R8 opp signs",    mk(1, 7, 'h9000), mk(0, 7, 'h9000), 0, '0);
        run_one("R12 a plus 0",    mk(1, 9, 'hABCD), '0, 0, mk(1, 9, 'hABCD));
        run_one("R12 a minus 0",   mk(0, 9, 'hABCD), '0, 1, mk(0, 9, 'hABCD));
        run_one("R3 zero minus b", '0, mk(0, 9, 'hABCD), 1, mk(1, 9, 'hABCD));
    endtask

    task automatic t_stream();
        // R2 R1: back-to-back operands with bubbles, against the reference model
        localparam int N = 64;
        logic [WORD_W-1:0] exp_q [N];
        bit                vld_q [N];
        for (int t = 0; t < N + 4; t++) begin
            @(negedge clk);
            if (t >= 4) begin
                check("R2 stream valid", WORD_W'(out_valid), WORD_W'(vld_q[t-4]));
                if (vld_q[t-4]) check("R1 stream result", out_res, exp_q[t-4]);
            end
            if (t < N) begin
                logic [WORD_W-1:0] a, b;
                bit s;
                a = mk(1'($urandom), 20 + int'($urandom % 180), 'h8000 | int'($urandom % 'h8000));
                b = mk(1'($urandom), 20 + int'($urandom % 180), 'h8000 | int'($urandom % 'h8000));
                if (t % 9 == 3) b = mk(a[WORD_W-1], 20 + int'($urandom % 12), 'h8000 | int'($urandom % 'h8000));
                if (t % 9 == 3) a[MAN_W +: EXP_W] = b[MAN_W +: EXP_W] + 1;
                s = 1'($urandom);
                vld_q[t] = (t % 7) != 5;
                exp_q[t] = ref_add(a, b, s);
                in_valid = vld_q[t]; opa = a; opb = b; in_sub = s;
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R2 watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_latency();
        t_arith();
        t_stream();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule